// File: doc/BRIEF.md
# PCI Bus Master Termination Sequencer

This block owns the FRAME# and IRDY# pins of a bridge's PCI master and decides how each transaction it starts comes to an end. An internal requester hands it a transaction: a direction, a data phase count and a flag that marks the requester as the bridge's line buffer. The block then runs the address phase and the data phases. It ends the transaction in one of three ways. The first is a normal completion after the last data phase. The second is a latency time-out, used when the arbiter has withdrawn the grant and the latency timer has run down. The third is a master abort, used when no target claims the cycle with DEVSEL# by a programmable sample clock.

Each data phase that finishes is reported to the requester as a response beat. Reads carry the target's data. Writes carry zero as an acknowledge. A single done pulse gives the kind of ending. A master abort never leads to a retry. A read that is aborted returns all-ones and a write that is aborted is acknowledged. An aborted line-buffer transaction moves no data at all. A sticky status bit records that a master abort happened. Configuration logic clears it by writing one.

Top module: `pci_mterm_ctrl`

## Requirements
- R1: After reset, and between transactions, FRAME# and IRDY# are both high and req_ready is 1. A request is taken only while req_ready is 1, and the address phase (FRAME# low, IRDY# high) is seen on the cycle after the request. A new FRAME# assertion only starts from the bus idle state, where both FRAME# and IRDY# are high.
- R2: Normal completion works as follows. IRDY# goes low on the clock after the address phase. FRAME# goes high for the final data phase while IRDY# stays low. After TRDY# is sampled low in the final phase, both pins go high. rsp_done then pulses with rsp_kind = 0, and exactly req_len beats have been returned (a req_len of 0 counts as 1).
- R3: The latency timer is loaded from cfg_lat_init when FRAME# is first driven low. It counts down once per clock while FRAME# is low and holds at zero. When the timer is zero, gnt_n is high and FRAME# is still low, FRAME# is released and the next data transfer is the last one. If this cuts the transaction short, rsp_kind = 1. While gnt_n is low, a zero timer has no effect.
- R4: cfg_dsel_pt values 0, 1, 2 and 3 select sample clock 1, 2, 3 and 4, counted after the address phase. DEVSEL# sampled low on any clock up to and including that one claims the cycle. DEVSEL# that first appears later still causes a master abort.
- R5: A master abort unfolds over three clocks. FRAME# is high with IRDY# still low on the clock after the sample clock. IRDY# goes high one clock later, and rsp_done pulses with rsp_kind = 2 on that same clock. The bus then stays idle until the next request, so there is no retry.
- R6: When a requester other than the line buffer is aborted, it gets exactly one response beat on the done cycle. The beat carries 32'hFFFF_FFFF for a read and zero (a plain acknowledge) for a write.
- R7: When the line buffer (req_lbuf = 1) is aborted, no response beat is produced.
- R8: mabort_sts goes to 1 on the clock FRAME# is released by a master abort and stays 1 until cfg_mabort_clr is 1 at a clock edge. If a set and a clear happen on the same edge, the set wins.
- R9: Each data phase in which TRDY# is sampled low with IRDY# low and the cycle claimed produces one response beat on the next clock. On a read the beat carries the ad_in value sampled on that edge, and on a write it carries zero. Beats come in bus order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester starts a transaction |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lbuf | input | 1 | Requester is the line buffer |
| req_len | input | LEN_W | Data phase count (0 treated as 1) |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| gnt_n | input | 1 | Bus grant, active low |
| devsel_n | input | 1 | Target claim, active low |
| trdy_n | input | 1 | Target ready, active low |
| ad_in | input | DW | Read data from the bus |
| cfg_dsel_pt | input | 2 | DEVSEL# sample clock select |
| cfg_lat_init | input | LAT_W | Latency timer preload |
| cfg_mabort_clr | input | 1 | Write-one-to-clear for mabort_sts |
| frame_n | output | 1 | FRAME#, active low |
| irdy_n | output | 1 | IRDY#, active low |
| rsp_valid | output | 1 | One response beat |
| rsp_data | output | DW | Beat data |
| rsp_done | output | 1 | Transaction finished |
| rsp_kind | output | 2 | 0 complete, 1 time-out, 2 master abort |
| mabort_sts | output | 1 | Sticky master-abort status |

## Verification
A wrong phase count or a stale claim flag shows up as an abort on the wrong clock, and the done pulse then lands outside the cycle that the sample-point setting implies. A timer or remaining-count error moves the clock on which FRAME# is released. That changes the number of beats and the ending kind reported in the same transaction. Errors in the abort path show at once on the done cycle as a missing or extra beat, wrong fill data, or a status bit that does not match the expected sticky value.

// File: rtl/pci_mterm_pkg.sv
package pci_mterm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_XFER  = 2'd2,
        ST_ABORT = 2'd3
    } mt_state_e;

    typedef enum logic [1:0] {
        END_DONE  = 2'd0,
        END_TMO   = 2'd1,
        END_ABORT = 2'd2
    } mt_end_e;

endpackage

// File: rtl/pci_mterm_lat.sv
module pci_mterm_lat #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    typedef struct packed {
        logic [LAT_W-1:0] cnt;
    } lat_s;

    lat_s q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.cnt = load_val;
        end else if (run && (q.cnt != '0)) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired = (q.cnt == '0);
endmodule

// File: rtl/pci_mterm_dsel.sv
module pci_mterm_dsel #(
    parameter int PT_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            active,
    input  logic            in_xfer,
    input  logic            devsel_n,
    input  logic [PT_W-1:0] sample_pt,
    output logic            claimed,
    output logic            miss
);
    localparam int PH_W   = PT_W + 1;
    localparam logic [PH_W-1:0] PH_MAX = {PH_W{1'b1}};

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            seen;
    } dsel_s;

    dsel_s q, d;
    logic [PH_W-1:0] limit;

    assign limit   = PH_W'(sample_pt) + 1'b1;
    assign claimed = q.seen | (in_xfer & ~devsel_n);
    assign miss    = in_xfer & ~claimed & (q.phase == limit);

    always_comb begin
        d = q;
        if (start) begin
            d.phase = '0;
            d.seen  = 1'b0;
        end else begin
            if (active && (q.phase != PH_MAX)) d.phase = q.phase + 1'b1;
            if (in_xfer && !devsel_n)          d.seen  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pci_mterm_sts.sv
module pci_mterm_sts (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic sts
);
    typedef struct packed {
        logic flag;
    } sts_s;

    sts_s q, d;

    always_comb begin
        d = q;
        if (set)      d.flag = 1'b1;
        else if (clr) d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sts = q.flag;
endmodule

// File: rtl/pci_mterm_ctrl.sv
module pci_mterm_ctrl
    import pci_mterm_pkg::*;
#(
    parameter int DW    = 32,
    parameter int LEN_W = 4,
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_lbuf,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_ready,
    input  logic             gnt_n,
    input  logic             devsel_n,
    input  logic             trdy_n,
    input  logic [DW-1:0]    ad_in,
    input  logic [1:0]       cfg_dsel_pt,
    input  logic [LAT_W-1:0] cfg_lat_init,
    input  logic             cfg_mabort_clr,
    output logic             frame_n,
    output logic             irdy_n,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_data,
    output logic             rsp_done,
    output logic [1:0]       rsp_kind,
    output logic             mabort_sts
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] LEN_TWO = LEN_W'(2);

    typedef struct packed {
        mt_state_e        state;
        logic             last;
        logic             tmo;
        logic [LEN_W-1:0] rem;
        logic             write;
        logic             lbuf;
        logic             frame_n;
        logic             irdy_n;
        logic             rsp_valid;
        logic [DW-1:0]    rsp_data;
        logic             done;
        mt_end_e          kind;
    } ctl_s;

    ctl_s q, d;

    logic start, active, in_xfer, claimed, miss, expired, tmo_now, xfer_ok;
    logic lbuf_flag;

    assign start   = (q.state == ST_IDLE) && req_valid;
    assign active  = (q.state == ST_ADDR) || (q.state == ST_XFER);
    assign in_xfer = (q.state == ST_XFER);
    assign tmo_now = expired && gnt_n;
    assign xfer_ok = in_xfer && !trdy_n && claimed;

    pci_mterm_lat #(.LAT_W(LAT_W)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (cfg_lat_init),
        .run      (!q.frame_n),
        .expired  (expired)
    );

    pci_mterm_dsel #(.PT_W(2)) u_dsel (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .active    (active),
        .in_xfer   (in_xfer),
        .devsel_n  (devsel_n),
        .sample_pt (cfg_dsel_pt),
        .claimed   (claimed),
        .miss      (miss)
    );

    pci_mterm_sts u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (miss),
        .clr   (cfg_mabort_clr),
        .sts   (mabort_sts)
    );

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        d.done      = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.state   = ST_ADDR;
                    d.write   = req_write;
                    d.lbuf    = req_lbuf;
                    d.rem     = (req_len == '0) ? LEN_ONE : req_len;
                    d.last    = (req_len == '0) || (req_len == LEN_ONE);
                    d.tmo     = 1'b0;
                    d.frame_n = 1'b0;
                    d.irdy_n  = 1'b1;
                end
            end
            ST_ADDR: begin
                d.state   = ST_XFER;
                d.irdy_n  = 1'b0;
                d.frame_n = q.last;
            end
            ST_XFER: begin
                if (miss) begin
                    d.state   = ST_ABORT;
                    d.frame_n = 1'b1;
                    d.irdy_n  = 1'b0;
                end else if (xfer_ok) begin
                    d.rsp_valid = 1'b1;
                    d.rsp_data  = q.write ? '0 : ad_in;
                    if (q.last) begin
                        d.state   = ST_IDLE;
                        d.frame_n = 1'b1;
                        d.irdy_n  = 1'b1;
                        d.done    = 1'b1;
                        d.kind    = q.tmo ? END_TMO : END_DONE;
                    end else begin
                        d.rem = q.rem - 1'b1;
                        if (q.rem == LEN_TWO) begin
                            d.last    = 1'b1;
                            d.frame_n = 1'b1;
                        end else if (tmo_now) begin
                            d.last    = 1'b1;
                            d.tmo     = 1'b1;
                            d.frame_n = 1'b1;
                        end
                    end
                end else if (!q.last && tmo_now) begin
                    d.last    = 1'b1;
                    d.tmo     = 1'b1;
                    d.frame_n = 1'b1;
                end
            end
            ST_ABORT: begin
                d.state     = ST_IDLE;
                d.frame_n   = 1'b1;
                d.irdy_n    = 1'b1;
                d.done      = 1'b1;
                d.kind      = END_ABORT;
                d.rsp_valid = !q.lbuf;
                d.rsp_data  = q.write ? '0 : '1;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= ST_IDLE;
            q.kind    <= END_DONE;
            q.frame_n <= 1'b1;
            q.irdy_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.state == ST_IDLE);
    assign frame_n   = q.frame_n;
    assign irdy_n    = q.irdy_n;
    assign rsp_valid = q.rsp_valid;
    assign rsp_data  = q.rsp_data;
    assign rsp_done  = q.done;
    assign rsp_kind  = q.kind;
    assign lbuf_flag = q.lbuf;
endmodule

// File: rtl/pci_mterm_chk.sv
module pci_mterm_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_n,
    input logic          irdy_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic          rsp_done,
    input logic [1:0]    rsp_kind,
    input logic          mabort_sts,
    input logic          cfg_mabort_clr,
    input logic          lbuf_flag
);
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && irdy_n) |-> req_ready);

    assert_start_from_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> $past(irdy_n));

    assert_irdy_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irdy_n) |-> $past(frame_n));

    assert_abort_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_kind == 2'd2) |-> ($past(frame_n) && !$past(irdy_n)));

    assert_abort_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_kind == 2'd2 && rsp_valid) |-> ((rsp_data == '1) || (rsp_data == '0)));

    assert_lbuf_no_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_kind == 2'd2 && lbuf_flag) |-> !rsp_valid);

    assert_sts_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mabort_sts) |-> (frame_n && !irdy_n));

    assert_sts_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mabort_sts) |-> $past(cfg_mabort_clr));
endmodule

bind pci_mterm_ctrl pci_mterm_chk #(.DW(DW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_n        (frame_n),
    .irdy_n         (irdy_n),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .rsp_data       (rsp_data),
    .rsp_done       (rsp_done),
    .rsp_kind       (rsp_kind),
    .mabort_sts     (mabort_sts),
    .cfg_mabort_clr (cfg_mabort_clr),
    .lbuf_flag      (lbuf_flag)
);

// File: tb/pci_mterm_ctrl_bench.sv
module pci_mterm_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int LEN_W = 4;
    localparam int LAT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_lbuf = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic req_ready;
    logic gnt_n = 1'b0, devsel_n = 1'b1, trdy_n = 1'b1;
    logic [DW-1:0] ad_in = '0;
    logic [1:0] cfg_dsel_pt = '0;
    logic [LAT_W-1:0] cfg_lat_init = '0;
    logic cfg_mabort_clr = 1'b0;
    logic frame_n, irdy_n, rsp_valid, rsp_done, mabort_sts;
    logic [DW-1:0] rsp_data;
    logic [1:0] rsp_kind;

    int n_cmp = 0;
    int n_bad = 0;
    logic exp_sts = 1'b0;

    int exp_kind;
    int exp_beats;
    logic [DW-1:0] exp_data [0:31];

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_mterm_ctrl #(.DW(DW), .LEN_W(LEN_W), .LAT_W(LAT_W)) u_pci_mterm_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_lbuf(req_lbuf), .req_len(req_len), .req_ready(req_ready),
        .gnt_n(gnt_n), .devsel_n(devsel_n), .trdy_n(trdy_n), .ad_in(ad_in),
        .cfg_dsel_pt(cfg_dsel_pt), .cfg_lat_init(cfg_lat_init),
        .cfg_mabort_clr(cfg_mabort_clr), .frame_n(frame_n), .irdy_n(irdy_n),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_done(rsp_done),
        .rsp_kind(rsp_kind), .mabort_sts(mabort_sts)
    );

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference outcome from the requirements (R2, R3, R4, R6, R7, R9).
    task automatic predict(input logic wr, input logic lb, input int n, input int pt,
                           input int dd, input int w, input int l, input logic gr);
        int rem;
        logic last, to;
        rem = (n == 0) ? 1 : n;
        last = (rem == 1);
        to = 1'b0;
        exp_beats = 0;
        if (dd == 0 || dd > pt + 1) begin
            exp_kind = 2;
            if (!lb) begin
                exp_data[0] = wr ? '0 : '1;
                exp_beats = 1;
            end
            return;
        end
        for (int p = 1; p < 200; p++) begin
            logic xf, tn;
            xf = (p >= dd) && (((p - dd) % (w + 1)) == w);
            tn = gr && (l <= p);
            if (xf) begin
                exp_data[exp_beats] = wr ? '0 : (32'hA500_0000 | 32'(p));
                exp_beats++;
                if (last) begin
                    exp_kind = to ? 1 : 0;
                    return;
                end
                rem--;
                if (rem == 1) last = 1'b1;
                else if (tn) begin last = 1'b1; to = 1'b1; end
            end else if (!last && tn) begin
                last = 1'b1;
                to = 1'b1;
            end
        end
    endtask

    task automatic run_txn(input logic wr, input logic lb, input int n, input int pt,
                           input int dd, input int w, input int l, input logic gr,
                           input logic hold_clr);
        int bi;
        int idx;
        logic got;
        predict(wr, lb, n, pt, dd, w, l, gr);
        check("R1 ready before request", req_ready == 1'b1, req_ready, 1);
        cfg_dsel_pt = pt[1:0];
        cfg_lat_init = l[LAT_W-1:0];
        gnt_n = gr;
        cfg_mabort_clr = hold_clr;
        req_write = wr;
        req_lbuf = lb;
        req_len = n[LEN_W-1:0];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        bi = 0;
        got = 1'b0;
        for (idx = 0; idx < 120; idx++) begin
            if (idx == 0)
                check("R1 address phase", frame_n == 1'b0 && irdy_n == 1'b1,
                      {frame_n, irdy_n}, 2'b01);
            if (rsp_valid) begin
                if (bi < exp_beats)
                    check(exp_kind == 2 ? "R6 abort beat data" : "R9 beat data",
                          rsp_data == exp_data[bi], rsp_data, exp_data[bi]);
                bi++;
            end
            if (hold_clr && exp_kind == 2 && idx == pt + 2)
                check("R8 set wins over clear", mabort_sts == 1'b1, mabort_sts, 1);
            if (rsp_done) begin
                got = 1'b1;
                check(exp_kind == 1 ? "R3 end kind" : (exp_kind == 2 ? "R5 end kind" : "R2 end kind"),
                      rsp_kind == 2'(exp_kind), rsp_kind, exp_kind);
                check(lb && exp_kind == 2 ? "R7 beat count" : "R2 beat count",
                      bi == exp_beats, bi, exp_beats);
                if (exp_kind == 2)
                    check("R4 R5 abort timing", idx == pt + 3, idx, pt + 3);
                break;
            end
            if (irdy_n == 1'b0 && dd != 0 && idx >= dd) begin
                devsel_n = 1'b0;
                trdy_n = !(((idx - dd) % (w + 1)) == w);
            end else begin
                devsel_n = 1'b1;
                trdy_n = 1'b1;
            end
            ad_in = 32'hA500_0000 | 32'(idx);
            @(negedge clk);
        end
        check("R2 done seen", got, got, 1);
        devsel_n = 1'b1;
        trdy_n = 1'b1;
        cfg_mabort_clr = 1'b0;
        if (hold_clr) exp_sts = 1'b0;
        else if (exp_kind == 2) exp_sts = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R5 bus idle no retry", frame_n && irdy_n && !rsp_valid,
                  {frame_n, irdy_n, rsp_valid}, 3'b110);
            check("R8 sticky status", mabort_sts == exp_sts, mabort_sts, exp_sts);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5173));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset pins", frame_n && irdy_n, {frame_n, irdy_n}, 2'b11);
        check("R1 reset ready", req_ready == 1'b1, req_ready, 1);
        check("R8 reset status", mabort_sts == 1'b0, mabort_sts, 0);
        check("R9 reset no beat", !rsp_valid && !rsp_done, {rsp_valid, rsp_done}, 0);

        run_txn(1'b0, 1'b0, 4, 0, 1, 0, 8, 1'b0, 1'b0);   // R2 R9 burst read
        run_txn(1'b1, 1'b0, 1, 1, 2, 0, 8, 1'b0, 1'b0);   // R2 single write
        run_txn(1'b0, 1'b0, 6, 0, 1, 1, 2, 1'b1, 1'b0);   // R3 time-out
        run_txn(1'b0, 1'b0, 5, 0, 1, 0, 0, 1'b0, 1'b0);   // R3 grant kept
        run_txn(1'b0, 1'b0, 3, 3, 4, 0, 9, 1'b0, 1'b0);   // R4 claim on last clock
        run_txn(1'b0, 1'b0, 2, 2, 0, 0, 9, 1'b0, 1'b0);   // R5 R6 abort read
        run_txn(1'b1, 1'b0, 2, 1, 3, 0, 9, 1'b0, 1'b0);   // R4 R6 late claim, write
        run_txn(1'b0, 1'b1, 4, 0, 0, 0, 9, 1'b0, 1'b0);   // R7 line buffer abort

        @(negedge clk);
        cfg_mabort_clr = 1'b1;
        @(negedge clk);
        cfg_mabort_clr = 1'b0;
        exp_sts = 1'b0;
        check("R8 clear by write", mabort_sts == 1'b0, mabort_sts, 0);

        run_txn(1'b0, 1'b0, 1, 3, 0, 0, 9, 1'b0, 1'b1);   // R8 set beats clear

        for (int t = 0; t < 60; t++) begin
            run_txn(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    int'($urandom_range(1, 6)), int'($urandom_range(0, 3)),
                    int'($urandom_range(0, 5)), int'($urandom_range(0, 2)),
                    int'($urandom_range(0, 8)), 1'($urandom_range(0, 1)), 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule